// File: doc/BRIEF.md
# Serial Register-Access Command Controller

This block is the slave end of a three-wire serial link (serial clock, data in, data out). Through it, an external host reads and writes a small internal register file. The block runs on the chip clock. It synchronises the serial clock and data inputs and detects the edges of the serial clock. It samples data in on each rising serial edge and updates data out after each falling serial edge. The serial clock idles high.

Every access starts with an 8-bit command byte, sent most significant bit first. The command selects one of four actions on one of eight register addresses:

- a single write,
- a single read,
- the start of a continuous read,
- the stop of a continuous read.

The block decodes the command and moves the register's bits in or out at that register's own width. On the register-file side it gives a parallel port with an address, a write strobe with write data, and a read strobe with read data. The block can be resynchronised at any time: a long unbroken run of ones on data in forces it back to waiting for a command.

Top module: `sercmd_ctrl`

## Requirements
- R1: After reset, data out is low, no strobe is raised, and the block waits for a command byte.
- R2: While waiting, each data-in bit sampled as 1 is ignored and nothing advances. The first bit sampled as 0 is bit 7 of a command, and the next seven sampled bits complete that command.
- R3: Command layout, received most significant bit first: bit 7 is the start bit (0), bits 5:4 are the action, and bits 2:0 are the register address. Bits 6 and 3 should be sent as 0.
- R4: Action 00 receives one data word, most significant bit first. If the register is writable, the block then pulses the write strobe for one clock, with the address and the right-aligned word on the port. The block then waits for a command again.
- R5: Register width depends on the address: addresses 0, 1 and 5 are 8 bits, address 3 is 16 bits, and addresses 2, 4, 6 and 7 are 24 bits.
- R6: Action 01 pulses the read strobe for one clock. Read data is taken during that clock. The word is then shifted out, most significant bit first, one bit per falling serial edge, starting with the first falling edge after the command. The block then waits for a command again.
- R7: Action 10 starts continuous read. When one read of the addressed register ends, the next read of the same register begins at once, with a new read strobe and no new command.
- R8: In continuous read, data in is watched at all times. If the byte 0x30 lands on a boundary of 8 bits counted from the start of a read, continuous read ends and the block waits for a command. The same bit pattern at any other alignment has no effect.
- R9: Thirty-two consecutive rising serial edges with data in high return the block to waiting for a command, from any state. Thirty-one such edges followed by a 0 do not.
- R10: Addresses 1 and 2 are read-only. A write to either of them takes the full data word but raises no write strobe, and the block then waits for a command again.
- R11: Data out is held low whenever no read word is being shifted out, including while write data is being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, idles high |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host |
| reg_addr | output | 3 | Register address from the last decoded command |
| reg_rd | output | 1 | One-clock read strobe; data is taken from reg_rdata in this clock |
| reg_wr | output | 1 | One-clock write strobe |
| reg_wdata | output | 24 | Write word, right-aligned to the register width |
| reg_rdata | input | 24 | Read word, right-aligned, valid for reg_addr |

## Verification
The bench starts a command behind a run of leading ones. A decoder that did not hold at the start bit would load those ones as command bits and write to the wrong address. It sends a continuous-read stop pattern that straddles a byte boundary, which a decoder without alignment would wrongly accept, and then a correctly aligned stop, which a decoder that missed it would treat as more read data. It drives thirty-one ones followed by a zero, then thirty-two ones, to catch a resync counter that is off by one in either direction. It also writes to a read-only address: a design that did not block it would show an extra write strobe.

// File: rtl/scr_pkg.sv
`timescale 1ns/1ps
package scr_pkg;

    localparam int DATA_W = 24;
    localparam int ADDR_W = 3;
    localparam logic [7:0] STOP_CODE = 8'h30;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_CMD,
        ST_WRITE,
        ST_LOAD,
        ST_READ
    } st_e;

    // Width in bits of the register at address a.
    function automatic int reg_len(input logic [ADDR_W-1:0] a);
        case (a)
            3'd0, 3'd1, 3'd5: return 8;
            3'd3:             return 16;
            default:          return 24;
        endcase
    endfunction

    function automatic logic reg_writable(input logic [ADDR_W-1:0] a);
        return !((a == 3'd1) || (a == 3'd2));
    endfunction

endpackage

// File: rtl/scr_edge_sync.sv
`timescale 1ns/1ps
module scr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic din,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic din_s
);

    typedef struct packed {
        logic [STAGES-1:0] ck;
        logic [STAGES-1:0] dn;
        logic              ck_prev;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d         = q;
        d.ck      = {q.ck[STAGES-2:0], sclk};
        d.dn      = {q.dn[STAGES-2:0], din};
        d.ck_prev = q.ck[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ck      <= '1;
            q.dn      <= '0;
            q.ck_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sclk_rise = q.ck[STAGES-1] & ~q.ck_prev;
    assign sclk_fall = ~q.ck[STAGES-1] & q.ck_prev;
    assign din_s     = q.dn[STAGES-1];

endmodule

// File: rtl/scr_ones_watch.sv
`timescale 1ns/1ps
module scr_ones_watch #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic bit_val,
    output logic trip
);

    localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign trip = bit_stb && bit_val && (cnt_q == CNT_W'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (bit_stb) begin
            if (!bit_val || trip) cnt_d = '0;
            else                  cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/scr_core.sv
`timescale 1ns/1ps
module scr_core
    import scr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              fall,
    input  logic              din_s,
    input  logic              trip,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              dout
);

    localparam int BCNT_W = $clog2(DATA_W);

    typedef struct packed {
        st_e               st;
        logic [BCNT_W-1:0] bcnt;
        logic [5:0]        cmd_sh;
        logic [DATA_W-1:0] sh;
        logic [7:0]        dbyte;
        logic [ADDR_W-1:0] addr;
        logic              cont;
        logic              dout;
        logic              wr;
        logic [DATA_W-1:0] wdata;
    } core_t;

    core_t d, q;
    logic [BCNT_W-1:0] last_bit;

    always_comb begin
        d        = q;
        d.wr     = 1'b0;
        last_bit = BCNT_W'(reg_len(q.addr) - 1);

        case (q.st)
            ST_WAIT: begin
                if (rise && !din_s) begin
                    d.st   = ST_CMD;
                    d.bcnt = '0;
                end
            end
            ST_CMD: begin
                if (rise) begin
                    d.cmd_sh = {q.cmd_sh[4:0], din_s};
                    d.bcnt   = q.bcnt + 1'b1;
                    if (q.bcnt == BCNT_W'(6)) begin
                        // seven bits after the start bit: [5:4] action, [2:0] address
                        d.addr  = {q.cmd_sh[1:0], din_s};
                        d.bcnt  = '0;
                        d.sh    = '0;
                        d.dbyte = '0;
                        case (q.cmd_sh[4:3])
                            2'b00: d.st = ST_WRITE;
                            2'b01: begin
                                d.st   = ST_LOAD;
                                d.cont = 1'b0;
                            end
                            2'b10: begin
                                d.st   = ST_LOAD;
                                d.cont = 1'b1;
                            end
                            default: begin
                                d.st   = ST_WAIT;
                                d.cont = 1'b0;
                            end
                        endcase
                    end
                end
            end
            ST_WRITE: begin
                if (rise) begin
                    d.sh   = {q.sh[DATA_W-2:0], din_s};
                    d.bcnt = q.bcnt + 1'b1;
                    if (q.bcnt == last_bit) begin
                        d.st   = ST_WAIT;
                        d.bcnt = '0;
                        if (reg_writable(q.addr)) begin
                            d.wr    = 1'b1;
                            d.wdata = d.sh;
                        end
                    end
                end
            end
            ST_LOAD: begin
                d.sh   = reg_rdata << (DATA_W - reg_len(q.addr));
                d.st   = ST_READ;
                d.bcnt = '0;
            end
            ST_READ: begin
                if (rise) begin
                    d.dbyte = {q.dbyte[6:0], din_s};
                    d.bcnt  = q.bcnt + 1'b1;
                    if (q.cont && (q.bcnt[2:0] == 3'd7) && (d.dbyte == STOP_CODE)) begin
                        d.st   = ST_WAIT;
                        d.cont = 1'b0;
                        d.bcnt = '0;
                    end else if (q.bcnt == last_bit) begin
                        d.st   = q.cont ? ST_LOAD : ST_WAIT;
                        d.bcnt = '0;
                    end
                end
                if (fall) begin
                    d.dout = q.sh[DATA_W-1];
                    d.sh   = {q.sh[DATA_W-2:0], 1'b0};
                end
            end
            default: d.st = ST_WAIT;
        endcase

        if (fall && (q.st != ST_READ)) d.dout = 1'b0;

        if (trip) begin
            d.st   = ST_WAIT;
            d.cont = 1'b0;
            d.bcnt = '0;
            d.wr   = 1'b0;
            d.dout = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= ST_WAIT;
            q.bcnt   <= '0;
            q.cmd_sh <= '0;
            q.sh     <= '0;
            q.dbyte  <= '0;
            q.addr   <= '0;
            q.cont   <= 1'b0;
            q.dout   <= 1'b0;
            q.wr     <= 1'b0;
            q.wdata  <= '0;
        end else begin
            q <= d;
        end
    end

    assign reg_addr  = q.addr;
    assign reg_rd    = (q.st == ST_LOAD);
    assign reg_wr    = q.wr;
    assign reg_wdata = q.wdata;
    assign dout      = q.dout;

endmodule

// File: rtl/sercmd_ctrl.sv
`timescale 1ns/1ps
module sercmd_ctrl
    import scr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ONES_LIMIT  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              din,
    output logic              dout,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);

    logic rise, fall, din_s, trip;

    scr_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .din       (din),
        .sclk_rise (rise),
        .sclk_fall (fall),
        .din_s     (din_s)
    );

    scr_ones_watch #(.LIMIT(ONES_LIMIT)) i_ones (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_stb (rise),
        .bit_val (din_s),
        .trip    (trip)
    );

    scr_core i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .fall      (fall),
        .din_s     (din_s),
        .trip      (trip),
        .reg_rdata (reg_rdata),
        .reg_addr  (reg_addr),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .dout      (dout)
    );

endmodule

// File: rtl/sercmd_ctrl_chk.sv
`timescale 1ns/1ps
module sercmd_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] reg_addr,
    input logic       reg_rd,
    input logic       reg_wr
);

    AST_WR_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_wr);                          // R4
    AST_WR_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_rd);                         // R4
    AST_RD_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) reg_rd |=> !reg_rd);                          // R6
    AST_ADDR_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) reg_rd |=> $stable(reg_addr));                // R7
    AST_RO_NO_WR:    assert property (@(posedge clk) disable iff (!rst_n) reg_wr |-> (reg_addr != 3'd1 && reg_addr != 3'd2)); // R10
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({reg_rd, reg_wr}));                  // R6

endmodule

bind sercmd_ctrl sercmd_ctrl_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr)
);

// File: tb/test_sercmd_ctrl.sv
`timescale 1ns/1ps
module test_sercmd_ctrl;

    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sclk;
    logic        din;
    logic        dout;
    logic [2:0]  reg_addr;
    logic        reg_rd;
    logic        reg_wr;
    logic [23:0] reg_wdata;
    logic [23:0] reg_rdata;
    logic [23:0] rf [8];

    int n_tests = 0;
    int n_fail  = 0;
    int wr_cnt  = 0;
    int rd_cnt  = 0;
    logic [2:0]  wr_addr;
    logic [23:0] wr_data;

    always #2.5 clk = ~clk;

    assign reg_rdata = rf[reg_addr];

    sercmd_ctrl i_sercmd_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .din       (din),
        .dout      (dout),
        .reg_addr  (reg_addr),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    always @(posedge clk) begin
        if (reg_wr) begin
            wr_cnt  <= wr_cnt + 1;
            wr_addr <= reg_addr;
            wr_data <= reg_wdata;
        end
        if (reg_rd) rd_cnt <= rd_cnt + 1;
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic xfer_bit(input logic v, output logic so);
        sclk = 1'b0;
        din  = v;
        repeat (HALF) tick();
        so   = dout;
        sclk = 1'b1;
        repeat (HALF) tick();
    endtask

    task automatic xfer(input logic [31:0] val, input int nb, output logic [31:0] got);
        got = '0;
        for (int i = nb - 1; i >= 0; i--) begin
            logic b;
            xfer_bit(val[i], b);
            got[i] = b;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        check("R1 dout after reset", {31'd0, dout}, 32'd0);
        check("R1 no write strobe", wr_cnt, 0);
        check("R1 no read strobe", rd_cnt, 0);
    endtask

    task automatic t_start_bit();
        logic [31:0] g;
        int w0 = wr_cnt;
        xfer(32'h1F, 5, g);               // R2 ones while waiting are ignored
        xfer(32'h03, 8, g);               // write, address 3
        xfer(32'hBEEF, 16, g);
        check("R2 one write after leading ones", wr_cnt - w0, 1);
        check("R3 address decoded", wr_addr, 3);
        check("R4 R5 16-bit write word", wr_data, 24'h00BEEF);
        check("R11 dout low during write", g, 0);
    endtask

    task automatic t_write_sizes();
        logic [31:0] g;
        int w0 = wr_cnt;
        xfer(32'h04, 8, g);
        xfer(32'h123456, 24, g);
        check("R5 24-bit write word", wr_data, 24'h123456);
        check("R4 address 4", wr_addr, 4);
        xfer(32'h05, 8, g);
        xfer(32'hA7, 8, g);
        check("R5 8-bit write word", wr_data, 24'h0000A7);
        check("R4 back to command wait", wr_cnt - w0, 2);
    endtask

    task automatic t_read_single();
        logic [31:0] g;
        int r0 = rd_cnt;
        xfer(32'h12, 8, g);
        xfer(32'h0, 24, g);
        check("R6 24-bit read", g, rf[2]);
        check("R6 one read strobe", rd_cnt - r0, 1);
        xfer(32'h11, 8, g);
        xfer(32'h0, 8, g);
        check("R6 R5 8-bit read", g, rf[1]);
        xfer(32'h13, 8, g);
        xfer(32'h0, 16, g);
        check("R6 R5 16-bit read", g, rf[3]);
        xfer(32'hFF, 8, g);
        check("R11 dout low after single read", g, 0);
        check("R6 no further read strobes", rd_cnt - r0, 3);
    endtask

    task automatic t_ro_write();
        logic [31:0] g;
        int w0 = wr_cnt;
        xfer(32'h02, 8, g);
        xfer(32'h00F00F, 24, g);
        xfer(32'h01, 8, g);
        xfer(32'h3C, 8, g);
        check("R10 read-only writes raise no strobe", wr_cnt - w0, 0);
        xfer(32'h06, 8, g);
        xfer(32'h0000AB, 24, g);
        check("R10 next command accepted", wr_cnt - w0, 1);
        check("R10 next write address", wr_addr, 6);
        check("R10 next write word", wr_data, 24'h0000AB);
    endtask

    task automatic t_cont_read();
        logic [31:0] g;
        int r0 = rd_cnt;
        xfer(32'h22, 8, g);
        for (int k = 0; k < 3; k++) begin
            xfer(32'h0, 24, g);
            check("R7 repeated read", g, rf[2]);
        end
        xfer(32'h030000, 24, g);          // 0x30 pattern off the byte boundary
        check("R8 misaligned stop ignored", g, rf[2]);
        xfer(32'h30, 8, g);               // aligned stop in first byte
        check("R8 data before stop", g, {24'd0, rf[2][23:16]});
        check("R7 read strobes in continuous read", rd_cnt - r0, 5);
        xfer(32'hFF, 8, g);
        check("R8 dout low after stop", g, 0);
        check("R8 no read strobe after stop", rd_cnt - r0, 5);
    endtask

    task automatic t_ones_resync();
        logic [31:0] g;
        int r0 = rd_cnt;
        int w0;
        int r1;
        xfer(32'h25, 8, g);
        xfer(32'h0, 8, g);
        check("R7 8-bit continuous read", g, {24'd0, rf[5][7:0]});
        xfer(32'hFFFFFFFE, 32, g);        // 31 ones then a zero
        check("R9 31 ones keep reading", g, {4{rf[5][7:0]}});
        xfer(32'h0, 8, g);
        check("R9 still in continuous read", g, {24'd0, rf[5][7:0]});
        check("R9 read strobe count", rd_cnt - r0, 7);
        xfer(32'hFFFFFFFF, 32, g);        // 32 ones resynchronise
        r1 = rd_cnt;
        xfer(32'hFFFF, 16, g);
        check("R9 dout low after resync", g, 0);
        check("R9 reads stopped after resync", rd_cnt - r1, 0);
        w0 = wr_cnt;
        xfer(32'h07, 8, g);
        xfer(32'h5A5A5A, 24, g);
        check("R9 command accepted after resync", wr_cnt - w0, 1);
        check("R9 write word after resync", wr_data, 24'h5A5A5A);
    endtask

    initial begin
        rf[0] = 24'h000011; rf[1] = 24'h00005A; rf[2] = 24'hC3A519; rf[3] = 24'h007E81;
        rf[4] = 24'h246802; rf[5] = 24'h000096; rf[6] = 24'h13579B; rf[7] = 24'hFEDCBA;
        rst_n = 1'b0;
        sclk  = 1'b1;
        din   = 1'b0;
        repeat (5) tick();
        rst_n = 1'b1;
        repeat (5) tick();
        t_reset();
        t_start_bit();
        t_write_sizes();
        t_read_single();
        t_ro_write();
        t_cont_read();
        t_ones_resync();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule